// File: doc/BRIEF.md
# Configurable Clock Output Controller

This block sits between the frequency synthesizer of a three-output clock generator and its output pads. Four configuration words are fixed at build time. A 2-bit select input chooses one of them, and the select may change while the chip runs. From the chosen word, the three output-enable pins, the power-down input and the synthesizer's lock flag, the block works out what each output does. An output can be running or stopped. It can take the synthesized clock or the bypass reference clock, it can be inverted, and when it is stopped it is either driven low or released to high impedance.

Each output has its own gate. The gate's request passes through a two-flop synchronizer clocked by that output's own clock. The gate register changes only while the output clock is low, so no shortened pulse ever reaches a pad. Outputs 0 and 1 can also be set up as one differential pair. In that mode, output 0 carries the true side and output 1 the complement, and only enable pin 1 controls the pair. Whenever the select changes, the lock indication used for gating is withdrawn for a hold-off window. Synthesized outputs then stay low until lock is reported again.

Top module: `clkgen_out_ctrl`

## Requirements
- R1: Each configuration word is 13 bits wide. Word k sits at bits [13k+12:13k] of the table parameter and is used when `sel` equals k. Bits [4i+3:4i] of a word describe output i, with bit 4i = enable, 4i+1 = bypass, 4i+2 = invert, 4i+3 = high-impedance-when-stopped. Bit 12 selects differential-pair mode.
- R2: A single-ended output runs only when its word enable bit and its `oe_pin` bit are both 1.
- R3: In differential-pair mode, `diff_mode_o` is 1 and the pair follows `oe_pin[1]` and enable bit 4. `oe_pin[0]` has no effect. Lane 1 drives `clk_o[0]`, `clk_o[1]` is its complement, and `oe_o[0]` equals `oe_o[1]`.
- R4: A stopped output has `clk_o` low. Its `oe_o` is 0 if its high-impedance bit is 1, and 1 otherwise.
- R5: While `pd_n` is 0, all of `clk_o` are 0 and all of `oe_o` are 1, with no clock edge needed.
- R6: Until lock is seen, enabled non-bypass single-ended outputs are driven low. The differential pair then sits with the true side at 0 and the complement side at 1.
- R7: A running output with its invert bit set carries the complement of its source clock.
- R8: A running output with its bypass bit set carries `ref_clk` and does not depend on `pll_lock`.
- R9: After an enable change, the output starts or stops within three rising edges of its own clock. The gate changes only while that clock is low.
- R10: After a change of the synchronized select, the lock indication stays low for at least HOLD_CYC `syn_clk` cycles. Non-bypass outputs stay low during that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| syn_clk | input | 1 | Synthesized clock from the PLL |
| ref_clk | input | 1 | Reference clock used by bypass outputs |
| pd_n | input | 1 | Asynchronous active-low power-down |
| pll_lock | input | 1 | Asynchronous lock flag from the PLL |
| sel | input | 2 | Configuration select |
| oe_pin | input | 3 | Per-output enable pins |
| clk_o | output | 3 | Gated clock outputs |
| oe_o | output | 3 | Per-output pad drive enable (0 = high impedance) |
| diff_mode_o | output | 1 | Outputs 0 and 1 form a differential pair |

## Verification
The hardest case to reach is the relock window after a select change. It lasts only a few tens of cycles, and it has to be seen while the lock flag stays high, so a short lock drop does not hide it. The bench switches the select with lock held steady. It samples the synthesized outputs inside the hold-off window and checks that they are low, then checks them again once the window has ended. Every output is sampled in both phases of the synthesized clock, so inversion and bypass can be told apart from a plain copy. The reference clock runs at a period and phase unrelated to the synthesized clock.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int NUM_OUT   = 3;
  localparam int NUM_CFG   = 4;
  localparam int LANE_BITS = 4;
  localparam int CFG_W     = NUM_OUT * LANE_BITS + 1;
  localparam int SEL_W     = $clog2(NUM_CFG);

  // per-output settings, enable in the least significant bit
  typedef struct packed {
    logic hiz;
    logic inv;
    logic byp;
    logic en;
  } lane_cfg_t;

  typedef struct packed {
    logic                     diff;
    lane_cfg_t [NUM_OUT-1:0]  lane;
  } cfg_word_t;
endpackage

// File: rtl/clk_lock_track.sv
module clk_lock_track
  import clkout_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic             syn_clk,
  input  logic             pd_n,
  input  logic             pll_lock,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_q_o,
  output logic             lock_ok_o,
  output logic             hold_busy_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             lk_s1, lk_s2;
  logic [SEL_W-1:0] sl_s1, sl_s2, sel_q;
  logic [CNT_W-1:0] hold_cnt;
  logic             lock_ok;

  always_ff @(posedge syn_clk or negedge pd_n) begin
    if (!pd_n) begin
      lk_s1    <= 1'b0;
      lk_s2    <= 1'b0;
      sl_s1    <= '0;
      sl_s2    <= '0;
      sel_q    <= '0;
      hold_cnt <= CNT_W'(HOLD_CYC);
      lock_ok  <= 1'b0;
    end else begin
      lk_s1 <= pll_lock;
      lk_s2 <= lk_s1;
      sl_s1 <= sel_i;
      sl_s2 <= sl_s1;
      if (sl_s2 != sel_q) begin
        sel_q    <= sl_s2;
        hold_cnt <= CNT_W'(HOLD_CYC);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      lock_ok <= lk_s2 && (hold_cnt == '0) && (sl_s2 == sel_q);
    end
  end

  assign sel_q_o     = sel_q;
  assign lock_ok_o   = lock_ok;
  assign hold_busy_o = (hold_cnt != '0);
endmodule

// File: rtl/clk_lane.sv
module clk_lane (
  input  logic syn_clk,
  input  logic ref_clk,
  input  logic pd_n,
  input  logic byp,
  input  logic inv,
  input  logic run_req,
  output logic lane_clk_o,
  output logic gate_o,
  output logic clk_o
);
  logic src_clk, lclk;
  logic req_s1, req_s2, gate;

  assign src_clk = byp ? ref_clk : syn_clk;
  assign lclk    = src_clk ^ inv;

  // request crosses into the lane's own clock
  always_ff @(posedge lclk or negedge pd_n) begin
    if (!pd_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= run_req;
      req_s2 <= req_s1;
    end
  end

  // gate moves only on the falling edge, while the lane clock is low
  always_ff @(negedge lclk or negedge pd_n) begin
    if (!pd_n) gate <= 1'b0;
    else       gate <= req_s2;
  end

  assign lane_clk_o = lclk;
  assign gate_o     = gate;
  assign clk_o      = lclk & gate;
endmodule

// File: rtl/clkgen_out_ctrl.sv
module clkgen_out_ctrl
  import clkout_pkg::*;
#(
  parameter int                        HOLD_CYC  = 16,
  parameter logic [NUM_CFG*CFG_W-1:0]  CFG_TABLE = {13'h1190, 13'h0337, 13'h0910, 13'h0359}
) (
  input  logic               syn_clk,
  input  logic               ref_clk,
  input  logic               pd_n,
  input  logic               pll_lock,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_OUT-1:0] oe_pin,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               diff_mode_o
);
  logic [SEL_W-1:0]   sel_q;
  logic               lock_ok;
  logic               hold_busy;
  cfg_word_t          cfg;
  logic [NUM_OUT-1:0] want, run_req, lane_clk, lane_gate, se_clk, se_oe;

  clk_lock_track #(.HOLD_CYC(HOLD_CYC)) u_lock (
    .syn_clk     (syn_clk),
    .pd_n        (pd_n),
    .pll_lock    (pll_lock),
    .sel_i       (sel),
    .sel_q_o     (sel_q),
    .lock_ok_o   (lock_ok),
    .hold_busy_o (hold_busy)
  );

  assign cfg = cfg_word_t'(CFG_TABLE[int'(sel_q)*CFG_W +: CFG_W]);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    // lane 0 is driven by lane 1 in pair mode, so its own pin is ignored
    if (i == 0) begin : g_pairable
      assign want[i] = cfg.lane[i].en & oe_pin[i] & ~cfg.diff;
    end else begin : g_plain
      assign want[i] = cfg.lane[i].en & oe_pin[i];
    end
    assign run_req[i] = want[i] & (cfg.lane[i].byp | lock_ok);
    assign se_oe[i]   = want[i] | lane_gate[i] | ~cfg.lane[i].hiz;

    clk_lane u_lane (
      .syn_clk    (syn_clk),
      .ref_clk    (ref_clk),
      .pd_n       (pd_n),
      .byp        (cfg.lane[i].byp),
      .inv        (cfg.lane[i].inv),
      .run_req    (run_req[i]),
      .lane_clk_o (lane_clk[i]),
      .gate_o     (lane_gate[i]),
      .clk_o      (se_clk[i])
    );
  end

  always_comb begin
    clk_o = se_clk;
    oe_o  = se_oe;
    if (cfg.diff) begin
      clk_o[0] = se_clk[1];
      clk_o[1] = ~se_clk[1];
      oe_o[0]  = se_oe[1];
      oe_o[1]  = se_oe[1];
    end
    if (!pd_n) begin
      clk_o = '0;
      oe_o  = '1;
    end
  end

  assign diff_mode_o = cfg.diff;
endmodule

// File: rtl/clkgen_out_ctrl_chk.sv
module clkgen_out_ctrl_chk
  import clkout_pkg::*;
(
  input logic               syn_clk,
  input logic               pd_n,
  input logic [SEL_W-1:0]   sel_q,
  input logic               lock_ok,
  input logic               hold_busy,
  input logic [NUM_OUT-1:0] lane_clk,
  input logic [NUM_OUT-1:0] lane_gate,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] oe_o,
  input logic               diff_mode_o
);
  // R5: power-down forces every output low and driven
  always @(pd_n or clk_o or oe_o) begin
    if (pd_n === 1'b0) begin
      p_pd_forced_r5: assert (clk_o == '0 && oe_o == '1)
        else $error("power-down outputs not forced");
    end
  end

  // R9: a gate may change only while its lane clock is low
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_gate
    always @(lane_gate[k]) begin
      if (pd_n === 1'b1) begin
        p_gate_low_phase_r9: assert (lane_clk[k] == 1'b0)
          else $error("gate changed while lane clock high");
      end
    end
  end

  // R10: a new select withdraws the lock indication
  p_sel_drops_lock_r10: assert property (@(posedge syn_clk) disable iff (!pd_n)
    (sel_q != $past(sel_q)) |-> !lock_ok);

  // R10: no lock indication while the hold-off counter runs
  p_holdoff_r10: assert property (@(posedge syn_clk) disable iff (!pd_n)
    hold_busy |=> !lock_ok);

  // R3: pair halves share one pad enable
  p_pair_oe_r3: assert property (@(posedge syn_clk) disable iff (!pd_n)
    diff_mode_o |-> (oe_o[0] == oe_o[1]));

  // R4: a released single-ended pad carries no clock
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_hiz
    p_hiz_quiet_r4: assert property (@(posedge syn_clk) disable iff (!pd_n)
      (!diff_mode_o && !oe_o[k]) |-> !clk_o[k]);
  end
endmodule

bind clkgen_out_ctrl clkgen_out_ctrl_chk u_chk (
  .syn_clk     (syn_clk),
  .pd_n        (pd_n),
  .sel_q       (sel_q),
  .lock_ok     (lock_ok),
  .hold_busy   (hold_busy),
  .lane_clk    (lane_clk),
  .lane_gate   (lane_gate),
  .clk_o       (clk_o),
  .oe_o        (oe_o),
  .diff_mode_o (diff_mode_o)
);

// File: tb/clkgen_out_ctrl_tb.sv
`timescale 1ns/100ps
module clkgen_out_ctrl_tb;
  logic       syn_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       pd_n;
  logic       pll_lock;
  logic [1:0] sel;
  logic [2:0] oe_pin;
  logic [2:0] clk_o, oe_o;
  logic       diff_mode_o;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  // wave kinds
  localparam int W_LOW = 0, W_SYN = 1, W_NSYN = 2, W_REF = 3, W_NREF = 4, W_HIGH = 5;

  clkgen_out_ctrl u_dut (
    .syn_clk(syn_clk), .ref_clk(ref_clk), .pd_n(pd_n), .pll_lock(pll_lock),
    .sel(sel), .oe_pin(oe_pin), .clk_o(clk_o), .oe_o(oe_o), .diff_mode_o(diff_mode_o)
  );

  always #5 syn_clk = ~syn_clk;
  initial begin
    #3;
    forever #15 ref_clk = ~ref_clk;
  end

  task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // samples output idx in both phases of syn_clk
  task automatic expect_wave(int idx, int kind, string req, int n = 4);
    logic e;
    for (int k = 0; k < 2 * n; k++) begin
      if (k % 2 == 0) @(posedge syn_clk);
      else            @(negedge syn_clk);
      #2;
      case (kind)
        W_SYN:   e = syn_clk;
        W_NSYN:  e = ~syn_clk;
        W_REF:   e = ref_clk;
        W_NREF:  e = ~ref_clk;
        W_HIGH:  e = 1'b1;
        default: e = 1'b0;
      endcase
      chk(req, $sformatf("clk_o[%0d]", idx), {3'b0, clk_o[idx]}, {3'b0, e});
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge syn_clk);
    #2;
  endtask

  task automatic t_reset;
    #1;
    chk("R5", "clk_o in power-down", {1'b0, clk_o}, 4'h0);
    chk("R5", "oe_o in power-down", {1'b0, oe_o}, 4'h7);
    @(negedge syn_clk); #1;
    pd_n = 1'b1;
  endtask

  task automatic t_prelock;
    settle(30);
    expect_wave(0, W_LOW, "R6");
    expect_wave(1, W_LOW, "R6");
    chk("R6", "oe_o driven before lock", {1'b0, oe_o}, 4'h7);
    expect_wave(2, W_REF, "R8 bypass without lock");
  endtask

  task automatic t_cfg0_run;
    pll_lock = 1'b1;
    settle(40);
    expect_wave(0, W_SYN, "R1 word0 out0");
    expect_wave(1, W_NSYN, "R7");
    expect_wave(2, W_REF, "R8");
  endtask

  task automatic t_pin_gating;
    oe_pin[0] = 1'b0;
    settle(3);
    chk("R9", "clk_o[0] stopped", {3'b0, clk_o[0]}, 4'h0);
    expect_wave(0, W_LOW, "R2");
    chk("R4", "oe_o[0] hiz", {3'b0, oe_o[0]}, 4'h0);
    oe_pin[0] = 1'b1;
    settle(3);
    expect_wave(0, W_SYN, "R9 restart");
    oe_pin[1] = 1'b0;
    settle(4);
    expect_wave(1, W_LOW, "R2");
    chk("R4", "oe_o[1] driven low", {3'b0, oe_o[1]}, 4'h1);
    oe_pin[1] = 1'b1;
    settle(4);
    expect_wave(1, W_NSYN, "R7 restart");
  endtask

  task automatic t_relock_cfg1;
    sel = 2'd1;
    settle(8);
    expect_wave(1, W_LOW, "R10 hold-off", 3);
    expect_wave(2, W_LOW, "R10 hold-off", 2);
    settle(30);
    expect_wave(0, W_LOW, "R2 word enable clear");
    chk("R4", "oe_o[0] driven", {3'b0, oe_o[0]}, 4'h1);
    expect_wave(1, W_SYN, "R10 after hold-off");
    expect_wave(2, W_SYN, "R1 word1 out2");
  endtask

  task automatic t_bypass_cfg2;
    sel = 2'd2;
    settle(40);
    expect_wave(0, W_NREF, "R7 inverted bypass");
    expect_wave(1, W_REF, "R8");
    pll_lock = 1'b0;
    settle(12);
    expect_wave(2, W_REF, "R8 unlocked");
    expect_wave(0, W_NREF, "R8 unlocked");
    pll_lock = 1'b1;
  endtask

  task automatic t_diff_cfg3;
    sel = 2'd3;
    settle(40);
    chk("R3", "diff_mode_o", {3'b0, diff_mode_o}, 4'h1);
    expect_wave(0, W_SYN, "R3 true side");
    expect_wave(1, W_NSYN, "R3 complement");
    oe_pin[0] = 1'b0;
    settle(6);
    expect_wave(0, W_SYN, "R3 oe_pin0 ignored");
    chk("R3", "oe_o pair with oe_pin0 low", {2'b0, oe_o[1:0]}, 4'h3);
    oe_pin[1] = 1'b0;
    settle(4);
    expect_wave(0, W_LOW, "R3");
    chk("R3", "pair released", {2'b0, oe_o[1:0]}, 4'h0);
    oe_pin = 3'b111;
    settle(6);
    pll_lock = 1'b0;
    settle(12);
    expect_wave(0, W_LOW, "R6 pair true");
    expect_wave(1, W_HIGH, "R6 pair complement");
    expect_wave(2, W_LOW, "R6");
  endtask

  task automatic t_powerdown;
    pll_lock = 1'b1;
    settle(30);
    pd_n = 1'b0;
    #1;
    chk("R5", "clk_o async", {1'b0, clk_o}, 4'h0);
    chk("R5", "oe_o async", {1'b0, oe_o}, 4'h7);
  endtask

  initial begin
    pd_n = 1'b0; pll_lock = 1'b0; sel = 2'd0; oe_pin = 3'b111;
    t_reset();
    t_prelock();
    t_cfg0_run();
    t_pin_gating();
    t_relock_cfg1();
    t_bypass_cfg2();
    t_diff_cfg3();
    t_powerdown();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule